// File: doc/BRIEF.md
# Half-Duplex Collision Jam and Backoff Controller

This block sits beside the transmit path of a half-duplex Ethernet MAC that moves four bits per clock. When the medium reports a collision while a frame is going out, it takes over the transmit nibble lanes and drives a 32-bit jam of all ones. If the collision arrives while the preamble is still being sent, it waits for the preamble to end before it starts the jam.

While the frame is out, the block counts how many data nibble clocks have gone by since the preamble ended. A collision inside the first 64 bytes (128 nibble clocks) counts as a normal collision. The block then backs off for a random whole number of slot times, each slot being 128 clocks, and asks the MAC to send the frame again. A collision after that point is a late collision. It is reported once and never retried. Backoff is truncated binary exponential. The sixteenth consecutive collision on one frame drops the frame and raises a retry-limit flag.

The MAC drives `tx_active` for each attempt, including its preamble, and drops it when the attempt ends. After a collision it drops `tx_active` and restarts only when `retry_req` pulses.

Top module: `hdx_collision_ctrl`

## Requirements
- R1: While reset is held and after it is released with no stimulus, jam_en, backoff_busy, retry_req, late_col and retry_limit are 0 and jam_data is 4'h0.
- R2: A collision that is accepted outside the preamble drives jam_en high, starting the cycle after col_det is sampled, for exactly 8 consecutive clocks, with jam_data equal to 4'hF during those clocks.
- R3: A collision that is accepted while preamble_active is high holds off the jam. The 8 jam clocks begin the cycle after preamble_active is first sampled low.
- R4: A non-late collision is followed, the cycle after the last jam clock, by backoff_busy for r*128+1 clocks. Then retry_req pulses for one clock. Here r is rand_in, masked as in R5, sampled on the clock edge that ends the jam.
- R5: After the n-th consecutive collision of a frame, only the low min(n,10) bits of rand_in form r. The other bits are ignored.
- R6: A collision accepted once 128 or more data clocks (tx_active high, preamble_active low) have passed in the current attempt is late. After its jam, late_col pulses for one clock, no backoff or retry follows, and the collision count returns to zero. A collision accepted at 127 data clocks is not late.
- R7: The 16th consecutive collision gives a one-clock retry_limit pulse after its jam, with no backoff and no retry_req, and resets the collision count to zero.
- R8: An attempt that ends (tx_active falls) with no collision resets the collision count to zero.
- R9: col_det has no effect while tx_active is low, while jamming and while backing off: no extra jam starts and the pending retry timing is unchanged.
- R10: jam_data is 4'h0 whenever jam_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, one nibble per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_active | input | 1 | MAC is sending the current attempt, preamble included |
| preamble_active | input | 1 | Preamble/start delimiter is on the lines |
| col_det | input | 1 | Collision indication from the PHY |
| rand_in | input | RAND_W | Free-running pseudo-random value |
| jam_en | output | 1 | Block owns the transmit nibble lanes |
| jam_data | output | 4 | Jam nibble, 4'hF while jamming |
| backoff_busy | output | 1 | Backoff wait in progress |
| retry_req | output | 1 | One-clock request to resend the frame |
| late_col | output | 1 | One-clock late-collision error |
| retry_limit | output | 1 | One-clock excess-retry error, frame dropped |

## Verification
The collision is placed at several positions in the frame: deep in data, in the preamble with the preamble held for several more cycles, and exactly at 127 and 128 data clocks. Together these separate the jam-deferral path, the normal retry path and the late path, and they show where the 64-byte boundary falls. Runs of consecutive collisions with rand_in all ones, and with only its top bit set, show how the backoff mask widens with each collision. Successful frames, late collisions and the sixteenth collision placed before a test collision show whether the collision count was cleared. Collisions poked in while jamming or backing off, and with tx_active low, must leave the observed retry time unchanged.

// File: rtl/hdx_collision_ctrl.sv
module hdx_collision_ctrl #(
  parameter int JAM_CLKS     = 8,
  parameter int SLOT_CLKS    = 128,
  parameter int LATE_CLKS    = 128,
  parameter int MAX_ATTEMPTS = 16,
  parameter int BACKOFF_CAP  = 10,
  parameter int RAND_W       = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_active,
  input  logic              preamble_active,
  input  logic              col_det,
  input  logic [RAND_W-1:0] rand_in,
  output logic              jam_en,
  output logic [3:0]        jam_data,
  output logic              backoff_busy,
  output logic              retry_req,
  output logic              late_col,
  output logic              retry_limit
);

  localparam int JW = (JAM_CLKS > 1) ? $clog2(JAM_CLKS) : 1;
  localparam int SW = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
  localparam int LW = $clog2(LATE_CLKS + 1);
  localparam int AW = $clog2(MAX_ATTEMPTS + 1);

  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_JAM, S_WAIT} state_t;

  state_t            state;
  logic [JW-1:0]     jam_cnt;
  logic [SW-1:0]     tick;
  logic [RAND_W-1:0] slots;
  logic [LW-1:0]     data_cnt;
  logic [AW-1:0]     attempts;
  logic              pend_late, pend_drop, frame_col, tx_q;
  logic [RAND_W-1:0] mask;
  logic              col_take, is_late, tx_ok;
  logic [AW-1:0]     att_next;

  always_comb begin
    for (int i = 0; i < RAND_W; i++)
      mask[i] = (int'(attempts) > i) && (i < BACKOFF_CAP);
  end

  assign col_take     = (state == S_IDLE) && tx_active && col_det;
  assign is_late      = data_cnt >= LW'(LATE_CLKS);
  assign att_next     = attempts + AW'(1);
  assign tx_ok        = (state == S_IDLE) && tx_q && !tx_active && !frame_col;
  assign jam_en       = (state == S_JAM);
  assign jam_data     = {4{jam_en}};
  assign backoff_busy = (state == S_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      jam_cnt     <= '0;
      tick        <= '0;
      slots       <= '0;
      data_cnt    <= '0;
      attempts    <= '0;
      pend_late   <= 1'b0;
      pend_drop   <= 1'b0;
      frame_col   <= 1'b0;
      tx_q        <= 1'b0;
      retry_req   <= 1'b0;
      late_col    <= 1'b0;
      retry_limit <= 1'b0;
    end else begin
      retry_req   <= 1'b0;
      late_col    <= 1'b0;
      retry_limit <= 1'b0;
      tx_q        <= tx_active;

      if (!tx_active)
        data_cnt <= '0;
      else if (!preamble_active && !is_late)
        data_cnt <= data_cnt + LW'(1);

      if (tx_active && !tx_q)
        frame_col <= 1'b0;
      if (tx_ok)
        attempts <= '0;

      unique case (state)
        S_IDLE: if (col_take) begin
          frame_col <= 1'b1;
          pend_late <= is_late;
          pend_drop <= !is_late && (att_next == AW'(MAX_ATTEMPTS));
          if (!is_late)
            attempts <= att_next;
          jam_cnt <= '0;
          state   <= preamble_active ? S_HOLD : S_JAM;
        end
        S_HOLD: if (!preamble_active)
          state <= S_JAM;
        S_JAM: if (jam_cnt == JW'(JAM_CLKS - 1)) begin
          if (pend_late) begin
            late_col <= 1'b1;
            attempts <= '0;
            state    <= S_IDLE;
          end else if (pend_drop) begin
            retry_limit <= 1'b1;
            attempts    <= '0;
            state       <= S_IDLE;
          end else begin
            slots <= rand_in & mask;
            tick  <= '0;
            state <= S_WAIT;
          end
        end else begin
          jam_cnt <= jam_cnt + JW'(1);
        end
        S_WAIT: if (slots == '0) begin
          retry_req <= 1'b1;
          state     <= S_IDLE;
        end else if (tick == SW'(SLOT_CLKS - 1)) begin
          tick  <= '0;
          slots <= slots - RAND_W'(1);
        end else begin
          tick <= tick + SW'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hdx_collision_chk.sv
module hdx_collision_chk #(
  parameter int JAM_CLKS = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       jam_en,
  input logic [3:0] jam_data,
  input logic       backoff_busy,
  input logic       retry_req,
  input logic       late_col,
  input logic       retry_limit
);

  logic [7:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else if (jam_en) run <= run + 8'd1;
    else run <= '0;
  end

  p_jam_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    jam_en |-> jam_data == 4'hF);
  p_jam_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(jam_en) |-> run == 8'(JAM_CLKS));
  p_jam_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !jam_en |-> jam_data == 4'h0);
  p_retry_after_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retry_req) |-> $past(backoff_busy));
  p_retry_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req |=> !retry_req);
  p_late_after_jam_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(late_col) |-> $past(jam_en));
  p_limit_after_jam_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retry_limit) |-> $past(jam_en));
  p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({retry_req, late_col, retry_limit}));

endmodule

bind hdx_collision_ctrl hdx_collision_chk #(.JAM_CLKS(JAM_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .jam_en(jam_en), .jam_data(jam_data),
  .backoff_busy(backoff_busy), .retry_req(retry_req),
  .late_col(late_col), .retry_limit(retry_limit)
);

// File: tb/hdx_collision_ctrl_tb.sv
module hdx_collision_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_active = 1'b0, preamble_active = 1'b0, col_det = 1'b0;
  logic [9:0] rand_in = '0;
  logic       jam_en, backoff_busy, retry_req, late_col, retry_limit;
  logic [3:0] jam_data;

  int checks = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;

  hdx_collision_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active),
    .preamble_active(preamble_active), .col_det(col_det), .rand_in(rand_in),
    .jam_en(jam_en), .jam_data(jam_data), .backoff_busy(backoff_busy),
    .retry_req(retry_req), .late_col(late_col), .retry_limit(retry_limit)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // kind: 1 retry, 2 late, 3 limit
  task automatic run_col(input int data_clks, input int pre_hold, input logic [9:0] rnd,
                         input int poke_at, input string req,
                         input int exp_kind, input int exp_r);
    int jam_start = -1, jam_len = 0, ev_kind = 0, ev_at = -1, busy_len = 0, bad = 0;
    int exp_at;
    @(negedge clk);
    tx_active = 1'b1;
    preamble_active = (pre_hold > 0);
    rand_in = rnd;
    repeat (data_clks) @(negedge clk);
    col_det = 1'b1;
    @(negedge clk);
    col_det = 1'b0;
    tx_active = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (jam_en) begin
        if (jam_start < 0) jam_start = i;
        jam_len++;
        if (jam_data != 4'hF) bad++;
      end else if (jam_data != 4'h0) bad++;
      if (backoff_busy) busy_len++;
      if (retry_req)   begin ev_kind = 1; ev_at = i; end
      if (late_col)    begin ev_kind = 2; ev_at = i; end
      if (retry_limit) begin ev_kind = 3; ev_at = i; end
      if (pre_hold > 0 && i == pre_hold - 1) preamble_active = 1'b0;
      if (i == poke_at)     begin tx_active = 1'b1; col_det = 1'b1; end
      if (i == poke_at + 1) begin tx_active = 1'b0; col_det = 1'b0; end
      if (ev_kind != 0) break;
      @(negedge clk);
    end
    preamble_active = 1'b0; tx_active = 1'b0; col_det = 1'b0;
    exp_at = pre_hold + ((exp_kind == 1) ? 9 + 128 * exp_r : 8);
    chk(jam_start == pre_hold, {req, " jam start"}, jam_start, pre_hold);
    chk(jam_len == 8, {req, " jam length R2"}, jam_len, 8);
    chk(bad == 0, {req, " jam data R10"}, bad, 0);
    chk(ev_kind == exp_kind, {req, " outcome"}, ev_kind, exp_kind);
    chk(ev_at == exp_at, {req, " outcome cycle"}, ev_at, exp_at);
    chk(busy_len == ((exp_kind == 1) ? 128 * exp_r + 1 : 0), {req, " backoff length R4"},
        busy_len, (exp_kind == 1) ? 128 * exp_r + 1 : 0);
    @(negedge clk);
    chk(!retry_req && !late_col && !retry_limit, {req, " single pulse"},
        {retry_req, late_col, retry_limit}, 0);
  endtask

  task automatic good_frame();
    @(negedge clk);
    tx_active = 1'b1;
    repeat (10) @(negedge clk);
    tx_active = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk({jam_en, backoff_busy, retry_req, late_col, retry_limit, jam_data} == '0,
        "R1 in reset", {jam_en, backoff_busy, retry_req, late_col, retry_limit}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({jam_en, backoff_busy, retry_req, late_col, retry_limit, jam_data} == '0,
        "R1 after reset", {jam_en, backoff_busy, retry_req, late_col, retry_limit}, 0);
  endtask

  task automatic t_basic();
    run_col(20, 0, 10'h000, -5, "R2 R4 basic r=0", 1, 0);
  endtask

  task automatic t_mask_growth();
    good_frame();
    run_col(10, 0, 10'h3FF, -5, "R8 R5 first after success", 1, 1);
    run_col(10, 0, 10'h3FF, -5, "R5 second collision", 1, 3);
    run_col(10, 0, 10'h3FF, -5, "R5 third collision", 1, 7);
  endtask

  task automatic t_late();
    run_col(128, 0, 10'h3FF, -5, "R6 late at 128", 2, 0);
    run_col(127, 0, 10'h3FF, -5, "R6 early at 127 count cleared", 1, 1);
  endtask

  task automatic t_preamble();
    run_col(0, 5, 10'h000, -5, "R3 preamble hold", 1, 0);
  endtask

  task automatic t_ignore();
    int seen = 0;
    @(negedge clk);
    col_det = 1'b1;
    @(negedge clk);
    col_det = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (jam_en || backoff_busy) seen++;
      @(negedge clk);
    end
    chk(seen == 0, "R9 idle collision ignored", seen, 0);
    good_frame();
    run_col(10, 0, 10'h3FF, 3, "R9 poke during jam", 1, 1);
    run_col(10, 0, 10'h3FF, 50, "R9 poke during backoff", 1, 3);
  endtask

  task automatic t_limit();
    good_frame();
    for (int n = 1; n <= 8; n++) run_col(10, 0, 10'h000, -5, "R7 retry run", 1, 0);
    run_col(10, 0, 10'h200, -5, "R5 ninth ignores bit 9", 1, 0);
    for (int n = 10; n <= 15; n++) run_col(10, 0, 10'h000, -5, "R7 retry run", 1, 0);
    run_col(10, 0, 10'h3FF, -5, "R7 sixteenth drops", 3, 0);
    run_col(10, 0, 10'h3FF, -5, "R7 count cleared", 1, 1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_mask_growth();
    t_late();
    t_preamble();
    t_ignore();
    t_limit();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule